// File: doc/BRIEF.md
# Video Layer Alpha Blend and Range Limiter

This block is a streaming pixel datapath for a display mixer. Each cycle it can accept one pair of 8-bit YCbCr 4:4:4 pixels: one from the video layer and one from the layer underneath. It mixes the video pixel onto the lower pixel using a single global blend factor that applies to the whole frame. It can then clamp the luma and the two chroma results to programmable ranges. The result appears with a valid strobe two cycles after the input.

Configuration is held in two 32-bit words, which are reached through a minimal write/read port. One is a control word with the blend code and two enables. The other is a bounds word. Writes land in pending copies that can be read back at once. The copies that steer the datapath pick up the pending values only at the frame-sync strobe, so a frame is never processed with a half-changed setup.

Top module: `vmix_blend_limit`

## Requirements
- R1: After reset, the control word reads 0x00000000 and the bounds word reads 0xEB10F010. This means luma upper 0xEB, luma lower 0x10, chroma upper 0xF0 and chroma lower 0x10.
- R2: In the control word (`reg_sel`=0), bits [7:0] are the blend code, bit 16 is the blend enable and bit 17 is the limiter enable. All other bits read as zero whatever was written.
- R3: A write (`reg_we`=1) stores into the pending copy selected by `reg_sel`, and `reg_rdata` returns it in the same cycle it is selected. Pixels keep using the active copy until the next `frame_sync`.
- R4: On a cycle with `frame_sync`=1, the active copies take the pending values held before that edge. A write in that same cycle becomes active only at a later sync.
- R5: With the blend enable clear, every output component equals the video component, before the limiter.
- R6: With blending on and code 0, the output equals the lower-layer pixel exactly, before the limiter.
- R7: With blending on and code c≠0, each component equals (a·V + (256−a)·L + 128) >> 8 with a = c+1. Code 0xFF therefore yields V exactly.
- R8: With the limiter on, Y is clamped to [bits 23:16, bits 31:24] of the bounds word. Cb and Cr are each clamped to [bits 7:0, bits 15:8].
- R9: With the limiter on and a lower bound above its upper bound, the affected components output that upper bound.
- R10: With the limiter off, the blended value passes unchanged, even outside the bounds.
- R11: `out_valid` is high exactly two cycles after a cycle with `pix_valid` high, and low otherwise.
- R12: A pixel entering in the same cycle as `frame_sync` is processed entirely with the configuration that was active before that sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control word, 1 bounds word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Pending value of the selected register |
| frame_sync | input | 1 | Frame-start strobe, loads the active configuration |
| pix_valid | input | 1 | Input pixel pair valid |
| vid_y | input | 8 | Video layer luma |
| vid_cb | input | 8 | Video layer blue chroma |
| vid_cr | input | 8 | Video layer red chroma |
| low_y | input | 8 | Lower layer luma |
| low_cb | input | 8 | Lower layer blue chroma |
| low_cr | input | 8 | Lower layer red chroma |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Output luma |
| out_cb | output | 8 | Output blue chroma |
| out_cr | output | 8 | Output red chroma |

## Verification
Register read data is combinational, so a read is checked one time step after the select is driven, in the same cycle. A pixel result is due two rising edges after its input cycle. The bench model pushes each input through a two-deep expected pipeline at every rising edge and compares valid and data at the following falling edge. A configuration change is modelled as taking effect at the sync edge itself, so the first pixel launched after that edge must show the new setting and a pixel launched alongside the sync must show the old one.

// File: rtl/vmix_pkg.sv
package vmix_pkg;

    localparam int CW      = 8;
    localparam int NCOMP   = 3;
    localparam int REG_W   = 32;
    localparam int AFRAC   = 8;
    localparam int AW      = AFRAC + 1;
    localparam int ACC_W   = CW + AW + 1;
    localparam int CODE_LSB   = 0;
    localparam int BLEND_BIT  = 16;
    localparam int LIMIT_BIT  = 17;

    typedef logic [CW-1:0]           comp_t;
    typedef comp_t [NCOMP-1:0]       pix_t;   // [0]=Y, [1]=Cb, [2]=Cr
    typedef logic [AW-1:0]           alpha_t;

    typedef struct packed {
        logic        lim_en;
        logic        blend_en;
        logic [7:0]  code;
    } mix_cfg_t;

    typedef struct packed {
        comp_t y_hi;
        comp_t y_lo;
        comp_t c_hi;
        comp_t c_lo;
    } lim_bounds_t;

    localparam mix_cfg_t    CFG_RST    = '{lim_en: 1'b0, blend_en: 1'b0, code: 8'h00};
    localparam lim_bounds_t BOUNDS_RST = '{y_hi: 8'hEB, y_lo: 8'h10, c_hi: 8'hF0, c_lo: 8'h10};

    function automatic mix_cfg_t cfg_unpack(input logic [REG_W-1:0] w);
        mix_cfg_t c;
        c.lim_en   = w[LIMIT_BIT];
        c.blend_en = w[BLEND_BIT];
        c.code     = w[CODE_LSB +: 8];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(input mix_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[LIMIT_BIT]      = c.lim_en;
        w[BLEND_BIT]      = c.blend_en;
        w[CODE_LSB +: 8]  = c.code;
        return w;
    endfunction

    function automatic alpha_t alpha_of(input logic [7:0] code);
        return (code == 8'd0) ? alpha_t'(0) : alpha_t'(code) + alpha_t'(1);
    endfunction

    function automatic comp_t blend_comp(input alpha_t a, input comp_t v, input comp_t l);
        logic [ACC_W-1:0] acc;
        alpha_t           inv;
        inv = alpha_t'(1 << AFRAC) - a;
        acc = ACC_W'(a) * ACC_W'(v) + ACC_W'(inv) * ACC_W'(l)
            + ACC_W'(1 << (AFRAC - 1));
        return acc[AFRAC +: CW];
    endfunction

    function automatic comp_t clamp_comp(input comp_t x, input comp_t lo, input comp_t hi);
        if (lo > hi)      return hi;
        else if (x < lo)  return lo;
        else if (x > hi)  return hi;
        else              return x;
    endfunction

endpackage

// File: rtl/vmix_regs.sv
module vmix_regs
    import vmix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             frame_sync,
    output logic [REG_W-1:0] rdata,
    output mix_cfg_t         act_cfg,
    output lim_bounds_t      act_bounds
);

    mix_cfg_t    pend_cfg;
    lim_bounds_t pend_bounds;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cfg    <= CFG_RST;
            pend_bounds <= BOUNDS_RST;
            act_cfg     <= CFG_RST;
            act_bounds  <= BOUNDS_RST;
        end else begin
            if (frame_sync) begin
                act_cfg    <= pend_cfg;
                act_bounds <= pend_bounds;
            end
            if (we) begin
                if (sel) pend_bounds <= lim_bounds_t'(wdata);
                else     pend_cfg    <= cfg_unpack(wdata);
            end
        end
    end

    always_comb begin
        rdata = sel ? REG_W'(pend_bounds) : cfg_pack(pend_cfg);
    end

    // R3: active copy is frozen between syncs
    p_hold_between_sync_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> ($stable(act_cfg) && $stable(act_bounds)));

    // R4: sync loads the pending values seen before the edge
    p_load_on_sync_r4: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (act_cfg == $past(pend_cfg) && act_bounds == $past(pend_bounds)));

endmodule

// File: rtl/vmix_blend_stage.sv
module vmix_blend_stage
    import vmix_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  pix_t        vid,
    input  pix_t        low,
    input  mix_cfg_t    cfg,
    input  lim_bounds_t bounds,
    output logic        o_valid,
    output pix_t        o_pix,
    output logic        o_lim_en,
    output lim_bounds_t o_bounds
);

    alpha_t alpha;
    pix_t   mixed;

    always_comb alpha = alpha_of(cfg.code);

    for (genvar i = 0; i < NCOMP; i++) begin : g_comp
        always_comb begin
            mixed[i] = cfg.blend_en ? blend_comp(alpha, vid[i], low[i]) : vid[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid  <= 1'b0;
            o_pix    <= '0;
            o_lim_en <= 1'b0;
            o_bounds <= BOUNDS_RST;
        end else begin
            o_valid  <= in_valid;
            o_pix    <= mixed;
            o_lim_en <= cfg.lim_en;
            o_bounds <= bounds;
        end
    end

    // R5: blend disabled replaces lower layer by video
    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg.blend_en) |=> (o_pix == $past(vid)));

    // R6: code zero is fully transparent
    p_transparent_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg.blend_en && cfg.code == 8'h00) |=> (o_pix == $past(low)));

    // R7: top code is fully opaque
    p_opaque_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg.blend_en && cfg.code == 8'hFF) |=> (o_pix == $past(vid)));

endmodule

// File: rtl/vmix_limit_stage.sv
module vmix_limit_stage
    import vmix_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  pix_t        in_pix,
    input  logic        lim_en,
    input  lim_bounds_t bounds,
    output logic        out_valid,
    output pix_t        out_pix
);

    pix_t limited;

    for (genvar i = 0; i < NCOMP; i++) begin : g_comp
        comp_t lo, hi;
        always_comb begin
            lo = (i == 0) ? bounds.y_lo : bounds.c_lo;
            hi = (i == 0) ? bounds.y_hi : bounds.c_hi;
            limited[i] = lim_en ? clamp_comp(in_pix[i], lo, hi) : in_pix[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            out_pix   <= limited;
        end
    end

    // R8: luma lands inside well-formed bounds
    p_luma_range_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lim_en && bounds.y_lo <= bounds.y_hi) |=>
        (out_pix[0] >= $past(bounds.y_lo) && out_pix[0] <= $past(bounds.y_hi)));

    // R9: inverted luma bounds force the upper bound
    p_inverted_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lim_en && bounds.y_lo > bounds.y_hi) |=>
        (out_pix[0] == $past(bounds.y_hi)));

    // R10: limiter off leaves the pixel untouched
    p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !lim_en) |=> (out_pix == $past(in_pix)));

endmodule

// File: rtl/vmix_blend_limit.sv
module vmix_blend_limit
    import vmix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             frame_sync,
    input  logic             pix_valid,
    input  logic [CW-1:0]    vid_y,
    input  logic [CW-1:0]    vid_cb,
    input  logic [CW-1:0]    vid_cr,
    input  logic [CW-1:0]    low_y,
    input  logic [CW-1:0]    low_cb,
    input  logic [CW-1:0]    low_cr,
    output logic             out_valid,
    output logic [CW-1:0]    out_y,
    output logic [CW-1:0]    out_cb,
    output logic [CW-1:0]    out_cr
);

    mix_cfg_t    act_cfg;
    lim_bounds_t act_bounds;
    pix_t        vid_pix, low_pix, mid_pix, fin_pix;
    logic        mid_valid, mid_lim_en;
    lim_bounds_t mid_bounds;

    always_comb begin
        vid_pix = '{vid_cr, vid_cb, vid_y};
        low_pix = '{low_cr, low_cb, low_y};
    end

    vmix_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .frame_sync (frame_sync),
        .rdata      (reg_rdata),
        .act_cfg    (act_cfg),
        .act_bounds (act_bounds)
    );

    vmix_blend_stage u_blend (
        .clk      (clk),
        .rst      (rst),
        .in_valid (pix_valid),
        .vid      (vid_pix),
        .low      (low_pix),
        .cfg      (act_cfg),
        .bounds   (act_bounds),
        .o_valid  (mid_valid),
        .o_pix    (mid_pix),
        .o_lim_en (mid_lim_en),
        .o_bounds (mid_bounds)
    );

    vmix_limit_stage u_limit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (mid_valid),
        .in_pix    (mid_pix),
        .lim_en    (mid_lim_en),
        .bounds    (mid_bounds),
        .out_valid (out_valid),
        .out_pix   (fin_pix)
    );

    always_comb begin
        out_y  = fin_pix[0];
        out_cb = fin_pix[1];
        out_cr = fin_pix[2];
    end

    // R11: valid travels through both stages, one cycle each
    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> mid_valid);
    p_latency_out_r11: assert property (@(posedge clk) disable iff (rst)
        mid_valid |=> out_valid);
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        !mid_valid |=> !out_valid);

    // R12: a pixel takes its limiter setup from launch time
    p_cfg_capture_r12: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> (mid_lim_en == $past(act_cfg.lim_en) && mid_bounds == $past(act_bounds)));

endmodule

// File: tb/vmix_blend_limit_test.sv
module vmix_blend_limit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_sync = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  vid_y = '0, vid_cb = '0, vid_cr = '0;
    logic [7:0]  low_y = '0, low_cb = '0, low_cr = '0;
    logic        out_valid;
    logic [7:0]  out_y, out_cb, out_cr;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_req  = "R5";

    always #10 clk = ~clk;

    vmix_blend_limit uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_sync(frame_sync),
        .pix_valid(pix_valid), .vid_y(vid_y), .vid_cb(vid_cb), .vid_cr(vid_cr),
        .low_y(low_y), .low_cb(low_cb), .low_cr(low_cr), .out_valid(out_valid),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_pend_cfg, m_act_cfg, m_pend_b, m_act_b;
    bit          m_v1, m_v2;
    logic [7:0]  m_p1 [3];
    logic [7:0]  m_p2 [3];

    function automatic logic [7:0] m_blend(logic [31:0] c, logic [7:0] v, logic [7:0] l);
        int a;
        if (!c[16]) return v;
        a = (c[7:0] == 0) ? 0 : int'(c[7:0]) + 1;
        return 8'((a * int'(v) + (256 - a) * int'(l) + 128) / 256);
    endfunction

    function automatic logic [7:0] m_clamp(bit en, logic [7:0] x, logic [7:0] lo, logic [7:0] hi);
        if (!en)    return x;
        if (lo > hi) return hi;
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pend_cfg = 32'h0; m_act_cfg = 32'h0;
            m_pend_b = 32'hEB10F010; m_act_b = 32'hEB10F010;
            m_v1 = 0; m_v2 = 0;
        end else begin
            logic [7:0] vv [3];
            logic [7:0] ll [3];
            vv = '{vid_y, vid_cb, vid_cr};
            ll = '{low_y, low_cb, low_cr};
            m_v2 = m_v1;
            m_p2 = m_p1;
            m_v1 = pix_valid;
            for (int i = 0; i < 3; i++) begin
                logic [7:0] lo, hi;
                lo = (i == 0) ? m_act_b[23:16] : m_act_b[7:0];
                hi = (i == 0) ? m_act_b[31:24] : m_act_b[15:8];
                m_p1[i] = m_clamp(m_act_cfg[17], m_blend(m_act_cfg, vv[i], ll[i]), lo, hi);
            end
            if (frame_sync) begin
                m_act_cfg = m_pend_cfg;
                m_act_b   = m_pend_b;
            end
            if (reg_we) begin
                if (reg_sel) m_pend_b   = reg_wdata;
                else         m_pend_cfg = reg_wdata & 32'h0003_00FF;
            end
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(out_valid == m_v2, "R11", 32'(out_valid), 32'(m_v2));
            if (m_v2) begin
                chk(out_y  == m_p2[0], cur_req, 32'(out_y),  32'(m_p2[0]));
                chk(out_cb == m_p2[1], cur_req, 32'(out_cb), 32'(m_p2[1]));
                chk(out_cr == m_p2[2], cur_req, 32'(out_cr), 32'(m_p2[2]));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            pix_valid = 0; reg_we = 0; frame_sync = 0;
        end
    endtask

    task automatic send_pix(logic [7:0] vy, logic [7:0] vb, logic [7:0] vr,
                            logic [7:0] ly, logic [7:0] lb, logic [7:0] lr);
        @(negedge clk);
        reg_we = 0; frame_sync = 0;
        pix_valid = 1;
        vid_y = vy; vid_cb = vb; vid_cr = vr;
        low_y = ly; low_cb = lb; low_cr = lr;
    endtask

    task automatic send_rand(int n);
        for (int k = 0; k < n; k++)
            send_pix(8'($urandom), 8'($urandom), 8'($urandom),
                     8'($urandom), 8'($urandom), 8'($urandom));
    endtask

    task automatic write_reg(bit sel, logic [31:0] d);
        @(negedge clk);
        pix_valid = 0; frame_sync = 0;
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic vsync();
        @(negedge clk);
        pix_valid = 0; reg_we = 0;
        frame_sync = 1;
        @(negedge clk);
        frame_sync = 0;
    endtask

    task automatic read_chk(bit sel, logic [31:0] exp, string req);
        @(negedge clk);
        pix_valid = 0; reg_we = 0; frame_sync = 0;
        reg_sel = sel;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset values
        read_chk(0, 32'h0000_0000, "R1");
        read_chk(1, 32'hEB10_F010, "R1");
        chk(out_valid == 0, "R1", 32'(out_valid), 0);

        // R2: reserved bits read as zero
        write_reg(0, 32'hFFFF_FFFF);
        read_chk(0, 32'h0003_00FF, "R2");
        write_reg(0, 32'h0000_0000);
        read_chk(0, 32'h0000_0000, "R2");

        // R5: blend off, video replaces lower layer
        vsync();
        cur_req = "R5";
        send_rand(8); idle(3);

        // R3: pending write has no effect on pixels before sync
        write_reg(0, 32'h0001_0080);
        read_chk(0, 32'h0001_0080, "R3");
        cur_req = "R3";
        send_pix(8'd200, 8'd50, 8'd10, 8'd0, 8'd255, 8'd100);
        send_rand(4); idle(3);

        // R7: mid blend after sync
        vsync();
        cur_req = "R7";
        send_pix(8'd200, 8'd50, 8'd10, 8'd0, 8'd255, 8'd100);
        send_rand(10); idle(3);
        write_reg(0, 32'h0001_00FF); vsync();
        cur_req = "R7";
        send_pix(8'd255, 8'd0, 8'd1, 8'd0, 8'd255, 8'd254);
        send_rand(6); idle(3);
        write_reg(0, 32'h0001_0001); vsync();
        send_rand(6); idle(3);

        // R6: code zero gives lower layer
        write_reg(0, 32'h0001_0000); vsync();
        cur_req = "R6";
        send_pix(8'd255, 8'd255, 8'd255, 8'd3, 8'd128, 8'd250);
        send_rand(6); idle(3);

        // R8: limiter with reset bounds, blend off
        write_reg(0, 32'h0002_0000); vsync();
        cur_req = "R8";
        send_pix(8'd0, 8'd0, 8'd255, 8'd0, 8'd0, 8'd0);
        send_pix(8'd255, 8'd255, 8'd0, 8'd0, 8'd0, 8'd0);
        send_pix(8'd16, 8'd240, 8'd235, 8'd0, 8'd0, 8'd0);
        send_rand(8); idle(3);

        // R8: programmed bounds with blending on
        write_reg(1, 32'hC040_A060);
        read_chk(1, 32'hC040_A060, "R8");
        write_reg(0, 32'h0003_0040); vsync();
        cur_req = "R8";
        send_rand(12); idle(3);

        // R9: inverted luma and chroma bounds
        write_reg(1, 32'h64C8_3050); vsync();
        cur_req = "R9";
        send_pix(8'd0, 8'd0, 8'd255, 8'd0, 8'd0, 8'd0);
        send_rand(6); idle(3);

        // R10: limiter off passes out-of-range values
        write_reg(0, 32'h0000_0000); vsync();
        cur_req = "R10";
        send_pix(8'd0, 8'd255, 8'd5, 8'd0, 8'd0, 8'd0);
        send_rand(4); idle(3);

        // R4 and R12: sync during a stream, write in the sync cycle
        write_reg(0, 32'h0003_0020);
        write_reg(1, 32'hEB10_F010);
        cur_req = "R12";
        send_rand(3);
        @(negedge clk);
        frame_sync = 1; pix_valid = 1;
        reg_we = 1; reg_sel = 0; reg_wdata = 32'h0001_00C0;
        vid_y = 8'd250; vid_cb = 8'd5; vid_cr = 8'd128;
        low_y = 8'd10; low_cb = 8'd200; low_cr = 8'd60;
        @(negedge clk);
        frame_sync = 0; reg_we = 0;
        cur_req = "R4";
        send_rand(5);
        idle(1);
        vsync();
        send_rand(5); idle(4);

        // R11: sparse valid pattern
        cur_req = "R11";
        for (int k = 0; k < 20; k++) begin
            if (($urandom & 1) != 0) send_rand(1);
            else idle(1);
        end
        idle(4);

        finish_run();
    end

endmodule